// File: doc/BRIEF.md
# Speculative Virtual-Channel and Switch Allocator

This block is the allocation stage of a virtual-channel router. It merges virtual-channel allocation with switch allocation. A head flit that already has its output port from route computation asks for an output VC and a crossbar slot in the same cycle. The head flit's pipeline is therefore route computation, then one combined allocation cycle, then switch traversal. Body and tail flits already own a VC, so they request only the crossbar slot for their output port. Such a request is non-speculative, and it is served ahead of any head flit that wants the same port.

A crossbar slot given to a head flit counts only if the same flit also wins a VC in that cycle. If it does not, the slot is voided and the crossbar output stays idle. The flit is flagged as wasted and retries both allocations later. Each output port has its own round-robin switch arbiter and its own round-robin VC arbiter. At most one VC per output port is handed out per cycle, because only one flit can cross that port per cycle. The granted VC is the lowest-numbered free VC of that port.

Each input presents one request as a valid/ready pair. `req_valid` is the valid, `sw_grant` is the ready, and a flit moves when both are high. The requester must hold `req_valid`, `req_head` and `req_port` steady until it sees `sw_grant`. A dropped request is simply not considered. The grants are combinational in the same cycle. The arbiter pointers update at the clock edge.

Top module: `spec_alloc`

## Requirements
- R1: For each output port, at most one input receives `sw_grant` in a cycle. An input receives `sw_grant` only while its `req_valid` is high.
- R2: When any valid body/tail request (`req_head`=0) targets port P, no head request for P receives `sw_grant` or `spec_waste` in that cycle.
- R3: A head flit receives `sw_grant` only together with `vc_grant`. `vc_grant` is asserted only together with `sw_grant` on a valid head request.
- R4: `vc_grant` is given only when the requested port has a free VC. Bit P*NUM_VC+v of `vc_free` marks VC v of port P as free. `vc_id` then carries the lowest free v of that port, and `vc_id` is 0 for an input without `vc_grant`.
- R5: `spec_waste` is raised for the head input chosen by the switch arbiter of a port when that input does not win the VC arbiter of the port. This covers the case where no VC of the port is free. A wasted input has no `sw_grant`.
- R6: `waste_count` equals the number of inputs with `spec_waste` high in the same cycle.
- R7: The switch arbiter of port P searches from its pointer upward, with wrap-around. After a used or wasted switch choice of input i, the pointer moves to i+1 (mod NUM_IN). Otherwise it holds.
- R8: The VC arbiter of port P searches head requests of P in the same way. Its pointer moves to i+1 only when head input i receives both grants. A wasted cycle leaves it unchanged.
- R9: After reset both pointers of every port are 0, so the lowest-numbered contender wins first.
- R10: With no valid request, all grant, waste and count outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the arbiter pointers |
| req_valid | input | NUM_IN | Per-input request valid |
| req_head | input | NUM_IN | Per-input flag: request comes from a head flit (speculative) |
| req_port | input | NUM_IN*PW | Per-input requested output port, PW bits each, input i at bits i*PW |
| vc_free | input | NUM_OUT*NUM_VC | Free flag of each output VC, bit P*NUM_VC+v |
| sw_grant | output | NUM_IN | Per-input used crossbar grant (ready) |
| vc_grant | output | NUM_IN | Per-input VC grant for a head flit |
| vc_id | output | NUM_IN*VW | Per-input granted VC number, VW bits each |
| spec_waste | output | NUM_IN | Per-input voided speculative switch grant |
| waste_count | output | CW | Number of voided speculative grants this cycle |

## Verification
The bench first runs one directed cycle right after reset, with every input sending a head to the same port, to confirm the pointers start at zero. A head-only phase follows in which at most one VC is free and only two ports are used. There the switch and VC arbiters often pick different inputs, which separates correct voiding and pointer holding from a design that lets a speculative grant through.

A mixed phase draws random heads and bodies over all ports and random VC-free masks. It exposes body-over-head priority errors and wrong lowest-free VC selection. A final phase aims every input at one port, which stresses the round-robin rotation of both arbiters under full contention.

// File: rtl/spec_alloc_pkg.sv
package spec_alloc_pkg;

  // Result of one output port's allocation in a cycle
  typedef enum logic [1:0] {
    SW_NONE       = 2'd0,  // no contender
    SW_BODY       = 2'd1,  // non-speculative winner
    SW_HEAD_OK    = 2'd2,  // head won switch and VC
    SW_HEAD_WASTE = 2'd3   // head won switch, lost VC: slot voided
  } sw_outcome_e;

endpackage

// File: rtl/spec_alloc_rr.sv
module spec_alloc_rr #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic          found,
  output logic [IW-1:0] idx
);

  // Search upward from ptr with wrap-around; first requester wins
  always_comb begin
    int c;
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < N; k++) begin
      c = int'(ptr) + k;
      if (c >= N) c = c - N;
      if (!found && req[c]) begin
        found = 1'b1;
        idx   = IW'(c);
      end
    end
  end

endmodule

// File: rtl/spec_alloc_port.sv
module spec_alloc_port
  import spec_alloc_pkg::*;
#(
  parameter int NUM_IN = 4,
  parameter int NUM_VC = 2,
  parameter int IW     = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  parameter int VW     = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] body_req,
  input  logic [NUM_IN-1:0] head_req,
  input  logic [NUM_VC-1:0] vc_free,
  output logic [NUM_IN-1:0] sw_gnt,
  output logic [NUM_IN-1:0] vc_gnt,
  output logic [NUM_IN-1:0] waste,
  output logic [VW-1:0]     vc_id
);

  logic [IW-1:0] sw_ptr, va_ptr;
  logic [NUM_IN-1:0] sw_cand, va_cand;
  logic sw_found, va_found, body_any, any_free;
  logic [IW-1:0] sw_idx, va_idx, nxt_idx;
  sw_outcome_e outcome;

  assign body_any = |body_req;
  assign any_free = |vc_free;
  // Non-speculative traffic shuts speculative heads out of the switch
  assign sw_cand  = body_any ? body_req : head_req;
  // Heads compete for a VC only if the port has one to give
  assign va_cand  = any_free ? head_req : '0;

  spec_alloc_rr #(.N(NUM_IN), .IW(IW)) u_sw_rr (
    .req(sw_cand), .ptr(sw_ptr), .found(sw_found), .idx(sw_idx)
  );

  spec_alloc_rr #(.N(NUM_IN), .IW(IW)) u_va_rr (
    .req(va_cand), .ptr(va_ptr), .found(va_found), .idx(va_idx)
  );

  // Lowest-numbered free VC of this port
  always_comb begin
    vc_id = '0;
    for (int v = NUM_VC - 1; v >= 0; v--) begin
      if (vc_free[v]) vc_id = VW'(v);
    end
  end

  always_comb begin
    outcome = SW_NONE;
    if (sw_found) begin
      if (body_any)                          outcome = SW_BODY;
      else if (va_found && va_idx == sw_idx) outcome = SW_HEAD_OK;
      else                                   outcome = SW_HEAD_WASTE;
    end
  end

  always_comb begin
    sw_gnt = '0;
    vc_gnt = '0;
    waste  = '0;
    case (outcome)
      SW_BODY:       sw_gnt = NUM_IN'(1) << sw_idx;
      SW_HEAD_OK: begin
        sw_gnt = NUM_IN'(1) << sw_idx;
        vc_gnt = NUM_IN'(1) << sw_idx;
      end
      SW_HEAD_WASTE: waste  = NUM_IN'(1) << sw_idx;
      default: ;
    endcase
  end

  assign nxt_idx = (int'(sw_idx) == NUM_IN - 1) ? '0 : sw_idx + IW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_ptr <= '0;
      va_ptr <= '0;
    end else begin
      // Switch pointer also moves past a voided head so arbiters cannot lock
      if (outcome != SW_NONE)   sw_ptr <= nxt_idx;
      if (outcome == SW_HEAD_OK) va_ptr <= nxt_idx;
    end
  end

endmodule

// File: rtl/spec_alloc.sv
module spec_alloc #(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 4,
  parameter int NUM_VC  = 2,
  localparam int PW = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
  localparam int VW = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int IW = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  localparam int CW = $clog2(NUM_IN + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IN-1:0]         req_valid,
  input  logic [NUM_IN-1:0]         req_head,
  input  logic [NUM_IN*PW-1:0]      req_port,
  input  logic [NUM_OUT*NUM_VC-1:0] vc_free,
  output logic [NUM_IN-1:0]         sw_grant,
  output logic [NUM_IN-1:0]         vc_grant,
  output logic [NUM_IN*VW-1:0]      vc_id,
  output logic [NUM_IN-1:0]         spec_waste,
  output logic [CW-1:0]             waste_count
);

  logic [NUM_IN-1:0] body_vec [NUM_OUT];
  logic [NUM_IN-1:0] head_vec [NUM_OUT];
  logic [NUM_IN-1:0] sw_vec   [NUM_OUT];
  logic [NUM_IN-1:0] vc_vec   [NUM_OUT];
  logic [NUM_IN-1:0] wst_vec  [NUM_OUT];
  logic [VW-1:0]     pid      [NUM_OUT];

  // Route each request to the allocator of its output port
  always_comb begin
    for (int o = 0; o < NUM_OUT; o++) begin
      for (int i = 0; i < NUM_IN; i++) begin
        body_vec[o][i] = req_valid[i] && !req_head[i] &&
                         (req_port[i*PW +: PW] == PW'(o));
        head_vec[o][i] = req_valid[i] && req_head[i] &&
                         (req_port[i*PW +: PW] == PW'(o));
      end
    end
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_port
    spec_alloc_port #(
      .NUM_IN(NUM_IN), .NUM_VC(NUM_VC), .IW(IW), .VW(VW)
    ) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .body_req (body_vec[o]),
      .head_req (head_vec[o]),
      .vc_free  (vc_free[o*NUM_VC +: NUM_VC]),
      .sw_gnt   (sw_vec[o]),
      .vc_gnt   (vc_vec[o]),
      .waste    (wst_vec[o]),
      .vc_id    (pid[o])
    );
  end

  // Merge per-port results back onto the inputs
  always_comb begin
    sw_grant    = '0;
    vc_grant    = '0;
    spec_waste  = '0;
    vc_id       = '0;
    waste_count = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      for (int o = 0; o < NUM_OUT; o++) begin
        if (sw_vec[o][i])  sw_grant[i]   = 1'b1;
        if (wst_vec[o][i]) spec_waste[i] = 1'b1;
        if (vc_vec[o][i]) begin
          vc_grant[i]         = 1'b1;
          vc_id[i*VW +: VW]   = pid[o];
        end
      end
      waste_count = waste_count + CW'(spec_waste[i]);
    end
  end

endmodule

// File: rtl/spec_alloc_chk.sv
module spec_alloc_chk #(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 4,
  parameter int NUM_VC  = 2,
  parameter int PW = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
  parameter int VW = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  parameter int CW = $clog2(NUM_IN + 1)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_IN-1:0]         req_valid,
  input logic [NUM_IN-1:0]         req_head,
  input logic [NUM_IN*PW-1:0]      req_port,
  input logic [NUM_OUT*NUM_VC-1:0] vc_free,
  input logic [NUM_IN-1:0]         sw_grant,
  input logic [NUM_IN-1:0]         vc_grant,
  input logic [NUM_IN*VW-1:0]      vc_id,
  input logic [NUM_IN-1:0]         spec_waste,
  input logic [CW-1:0]             waste_count
);

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_po
    logic [NUM_IN-1:0] here, body_here;
    always_comb begin
      for (int i = 0; i < NUM_IN; i++) begin
        here[i]      = req_valid[i] && (req_port[i*PW +: PW] == PW'(o));
        body_here[i] = here[i] && !req_head[i];
      end
    end

    assert_one_grant_per_port_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sw_grant & here) <= 1);

    assert_body_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|body_here) |-> ((sw_grant & here & req_head) == '0 && (spec_waste & here) == '0));
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    assert_grant_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
      sw_grant[i] |-> req_valid[i]);

    assert_vc_with_switch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      vc_grant[i] |-> (sw_grant[i] && req_head[i] && req_valid[i]));

    assert_head_switch_has_vc_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_grant[i] && req_head[i]) |-> vc_grant[i]);

    assert_vc_is_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
      vc_grant[i] |-> vc_free[int'(req_port[i*PW +: PW])*NUM_VC + int'(vc_id[i*VW +: VW])]);

    assert_waste_excludes_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
      spec_waste[i] |-> (!sw_grant[i] && !vc_grant[i] && req_head[i] && req_valid[i]));
  end

  assert_waste_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    waste_count == CW'($countones(spec_waste)));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid == '0) |-> (sw_grant == '0 && vc_grant == '0 && spec_waste == '0));

endmodule

bind spec_alloc spec_alloc_chk #(
  .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .NUM_VC(NUM_VC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_head(req_head),
  .req_port(req_port), .vc_free(vc_free), .sw_grant(sw_grant),
  .vc_grant(vc_grant), .vc_id(vc_id), .spec_waste(spec_waste),
  .waste_count(waste_count)
);

// File: tb/spec_alloc_test.sv
module spec_alloc_test;

  localparam int NI = 4, NO = 4, NV = 2, PW = 2, VW = 1, CW = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic rst_n;
  logic [NI-1:0]    req_valid, req_head;
  logic [NI*PW-1:0] req_port;
  logic [NO*NV-1:0] vc_free;
  logic [NI-1:0]    sw_grant, vc_grant, spec_waste;
  logic [NI*VW-1:0] vc_id;
  logic [CW-1:0]    waste_count;

  spec_alloc #(.NUM_IN(NI), .NUM_OUT(NO), .NUM_VC(NV)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_head(req_head),
    .req_port(req_port), .vc_free(vc_free), .sw_grant(sw_grant),
    .vc_grant(vc_grant), .vc_id(vc_id), .spec_waste(spec_waste),
    .waste_count(waste_count)
  );

  int errors = 0, checks = 0;
  int swp [NO];
  int vap [NO];
  logic [31:0] lfsr = 32'h1ACE_5EED;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  // Drive one cycle at the falling edge, compare mid-cycle, advance the model
  task automatic apply(input logic [NI-1:0] v, input logic [NI-1:0] h,
                       input logic [NI*PW-1:0] p, input logic [NO*NV-1:0] f);
    logic [NI-1:0] es, ev, ew;
    int eid [NI];
    int ecount;
    @(negedge clk);
    req_valid = v; req_head = h; req_port = p; vc_free = f;
    #5;
    es = '0; ev = '0; ew = '0; ecount = 0;
    for (int i = 0; i < NI; i++) eid[i] = 0;
    for (int o = 0; o < NO; o++) begin
      logic [NI-1:0] body, head, cand;
      int w, vw, fidx;
      body = '0; head = '0;
      for (int i = 0; i < NI; i++) begin
        if (v[i] && int'(p[i*PW +: PW]) == o) begin
          if (h[i]) head[i] = 1'b1; else body[i] = 1'b1;
        end
      end
      cand = (body != '0) ? body : head;
      w = -1;
      for (int k = 0; k < NI; k++)
        if (w < 0 && cand[(swp[o] + k) % NI]) w = (swp[o] + k) % NI;
      fidx = -1;
      for (int x = NV - 1; x >= 0; x--) if (f[o*NV + x]) fidx = x;
      vw = -1;
      if (fidx >= 0)
        for (int k = 0; k < NI; k++)
          if (vw < 0 && head[(vap[o] + k) % NI]) vw = (vap[o] + k) % NI;
      if (w >= 0) begin
        if (!h[w]) es[w] = 1'b1;
        else if (vw == w) begin
          es[w] = 1'b1; ev[w] = 1'b1; eid[w] = fidx;
          vap[o] = (w + 1) % NI;
        end else begin
          ew[w] = 1'b1; ecount++;
        end
        swp[o] = (w + 1) % NI;
      end
    end
    for (int i = 0; i < NI; i++) begin
      check(sw_grant[i] == es[i], "R1 R2 R7 sw_grant", int'(sw_grant[i]), int'(es[i]));
      check(vc_grant[i] == ev[i], "R3 R8 vc_grant", int'(vc_grant[i]), int'(ev[i]));
      check(int'(vc_id[i*VW +: VW]) == eid[i], "R4 vc_id", int'(vc_id[i*VW +: VW]), eid[i]);
      check(spec_waste[i] == ew[i], "R5 spec_waste", int'(spec_waste[i]), int'(ew[i]));
    end
    check(int'(waste_count) == ecount, "R6 waste_count", int'(waste_count), ecount);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = '0; req_head = '0; req_port = '0; vc_free = '0;
    for (int o = 0; o < NO; o++) begin swp[o] = 0; vap[o] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R10: idle cycle keeps every output low
    apply('0, '0, '0, '1);
    check(sw_grant == '0 && vc_grant == '0 && spec_waste == '0 && waste_count == '0,
          "R10 idle outputs", int'(sw_grant), 0);

    // R9: fresh pointers, all heads to port 0: input 0 wins both
    apply(4'hF, 4'hF, '0, '1);
    check(sw_grant == 4'b0001, "R9 reset pointer sw_grant", int'(sw_grant), 1);
    check(vc_grant == 4'b0001, "R9 reset pointer vc_grant", int'(vc_grant), 1);

    // R2: body on port 1 beats head on port 1
    apply(4'b0011, 4'b0001, {2'd0, 2'd0, 2'd1, 2'd1}, '1);
    check(sw_grant == 4'b0010 && spec_waste == '0, "R2 body priority", int'(sw_grant), 2);

    // Phase A: heads only, two ports, at most one free VC per port
    for (int n = 0; n < 1000; n++) begin
      logic [NI*PW-1:0] p;
      logic [NO*NV-1:0] f;
      lfsr = next_rand(lfsr);
      for (int i = 0; i < NI; i++) p[i*PW +: PW] = {1'b0, lfsr[i]};
      f = '0;
      for (int o = 0; o < NO; o++) if (lfsr[8+o]) f[o*NV + int'(lfsr[12+o])] = 1'b1;
      apply(lfsr[23:20], '1, p, f);
    end

    // Phase B: mixed heads and bodies over all ports, random free masks
    for (int n = 0; n < 1200; n++) begin
      lfsr = next_rand(lfsr);
      apply(lfsr[3:0], lfsr[7:4], lfsr[15:8], lfsr[23:16]);
    end

    // Phase C: every input aims at port 2
    for (int n = 0; n < 800; n++) begin
      lfsr = next_rand(lfsr);
      apply(lfsr[3:0] | 4'b0001, lfsr[7:4], {2'd2, 2'd2, 2'd2, 2'd2}, lfsr[15:8]);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule